// File: doc/BRIEF.md
# Six-Step Commutation Output Sequencer

This block drives three complementary output pairs in the six-step pattern used to commutate a brushless motor. Software loads the step it wants next into a shadow register while the current step drives the outputs. A commutation event then copies the whole shadow step into the active step in one clock, so all six outputs change together. A commutation event is either a one-cycle software strobe or a rising edge on a trigger input. Each event also sets a flag that software clears once it has loaded the following step.

The block has four more parts. An up-counting time base wraps at a programmable period and marks each wrap with an update event. Per-output dead-time insertion holds back every newly activated output so that it cannot overlap its partner. A main output enable gates the pattern onto the pins. A break input, brought in through a two-flop synchronizer, clears that enable and forces every pin to its programmed idle level. With automatic re-enable selected, the main output enable comes back at the first update event after break has cleared.

Top module: `sixstep_seq`

## Requirements
- R1: While and right after reset, the active step is 1, the shadow step is 1, the main output enable is 0, the commutation flag is 0, the counter is 0, and `drv` equals `idle_lvl`.
- R2: `drv` bit order is {CH3N, CH3, CH2N, CH2, CH1N, CH1}, from bit 5 down to bit 0. In steady state with the enable set and no break, the steps produce these values: step 1 → 6'b001001, step 2 → 6'b011000, step 3 → 6'b010010, step 4 → 6'b000110, step 5 → 6'b100100, step 6 → 6'b100001.
- R3: A shadow write with value 1 to 6 changes neither the active step nor `drv` until a commutation event. An event in the same cycle as a write uses the old shadow value. A write of 0 or 7 leaves the shadow unchanged.
- R4: A commutation event occurs when `com_strobe` is high, or when `com_trig` is high and was low in the previous cycle. A trigger held high causes only one event. A strobe and a trigger edge in the same cycle form one event. `step_idx` takes the shadow value at the edge where the event is sampled.
- R5: A commutation event sets `com_flag`. `flag_clr` clears it. When both occur in the same cycle, the flag is set.
- R6: `count` advances by one each cycle and returns to 0 on the edge after it equals `period`. `upd_evt` is high exactly while `count` equals `period` (or exceeds it).
- R7: Take a commutation sampled at edge E. An output that turns off goes low after edge E+1. An output that turns on goes high after edge E+1+`dead_time`. An output that stays on is unaffected.
- R8: `brk_in` passes through two flops. `drv` equals `idle_lvl` from the second edge after `brk_in` rises, and the enable is 0 after the third. The pins stay idle even when a commutation is loaded in that cycle, although the step still changes.
- R9: `moe_set` sets the enable when break is inactive. While the enable is 0, `drv` equals `idle_lvl`. With `aoe_en` low, the enable stays 0 after break clears.
- R10: With `aoe_en` high, the enable returns to 1 at the first update event after the synchronized break is low. At that moment the counter reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| period | input | CNT_W | Time base wrap value |
| dead_time | input | DT_W | Turn-on delay in cycles |
| idle_lvl | input | 6 | Pin levels while disabled or in break |
| moe_set | input | 1 | Set main output enable (pulse) |
| aoe_en | input | 1 | Automatic re-enable after break |
| brk_in | input | 1 | Asynchronous active-high break |
| shadow_wr | input | 1 | Write `shadow_step` into shadow |
| shadow_step | input | 3 | Next step number, 1 to 6 |
| com_strobe | input | 1 | Software commutation strobe |
| com_trig | input | 1 | Commutation trigger, rising edge |
| flag_clr | input | 1 | Clear commutation flag |
| count | output | CNT_W | Time base counter |
| upd_evt | output | 1 | Counter update (wrap) event |
| step_idx | output | 3 | Active step number |
| moe | output | 1 | Main output enable |
| com_flag | output | 1 | Commutation interrupt flag |
| drv | output | 6 | Output pins {CH3N,CH3,CH2N,CH2,CH1N,CH1} |

## Verification
The test concentrates on break and commutation landing in the same cycle. The bench raises `brk_in` and, on the edge where the synchronized break becomes active, also issues a software strobe with a new step preloaded. It then expects the pins to read the idle pattern, the active step to show the newly loaded value, and the enable to drop one edge later. The strobe and a trigger edge are also applied together, and the bench expects a single step change and a set flag.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

    localparam int NUM_PH  = 3;
    localparam int NUM_OUT = 2 * NUM_PH;

    typedef logic [NUM_OUT-1:0] drv_vec_t;

    typedef enum logic [2:0] {
        ST_NONE = 3'd0,
        ST_1    = 3'd1,
        ST_2    = 3'd2,
        ST_3    = 3'd3,
        ST_4    = 3'd4,
        ST_5    = 3'd5,
        ST_6    = 3'd6,
        ST_BAD  = 3'd7
    } step_e;

    // Leg of one phase: high side on even bit, low side on odd bit.
    typedef struct packed {
        logic lo;
        logic hi;
    } leg_t;

    function automatic logic step_ok(logic [2:0] v);
        return (v != 3'd0) && (v != 3'd7);
    endfunction

    function automatic leg_t leg(logic hi_on, logic lo_on);
        leg_t l;
        l.hi = hi_on;
        l.lo = lo_on;
        return l;
    endfunction

    function automatic drv_vec_t step_pattern(step_e s);
        leg_t p1, p2, p3;
        p1 = leg(s == ST_1 || s == ST_6, s == ST_3 || s == ST_4);
        p2 = leg(s == ST_4 || s == ST_5, s == ST_1 || s == ST_2);
        p3 = leg(s == ST_2 || s == ST_3, s == ST_5 || s == ST_6);
        return {p3, p2, p1};
    endfunction

endpackage

// File: rtl/ss_timebase.sv
module ss_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    output logic [CNT_W-1:0] count,
    output logic             upd_evt
);

    logic [CNT_W-1:0] cnt_q;

    assign upd_evt = (cnt_q >= period);
    assign count   = cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (upd_evt) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/ss_commute.sv
module ss_commute
    import sixstep_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       shadow_wr,
    input  logic [2:0] shadow_step,
    input  logic       com_strobe,
    input  logic       com_trig,
    input  logic       flag_clr,
    output logic       com_evt,
    output step_e      active_step,
    output drv_vec_t   raw_pat,
    output logic       com_flag
);

    step_e shadow_q;
    step_e active_q;
    logic  trig_q;
    logic  flag_q;

    assign com_evt     = com_strobe | (com_trig & ~trig_q);
    assign active_step = active_q;
    assign raw_pat     = step_pattern(active_q);
    assign com_flag    = flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            shadow_q <= ST_1;
            active_q <= ST_1;
            trig_q   <= 1'b0;
            flag_q   <= 1'b0;
        end else begin
            trig_q <= com_trig;
            if (com_evt) begin
                active_q <= shadow_q;
            end
            if (shadow_wr && step_ok(shadow_step)) begin
                shadow_q <= step_e'(shadow_step);
            end
            if (com_evt) begin
                flag_q <= 1'b1;
            end else if (flag_clr) begin
                flag_q <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ss_deadtime.sv
module ss_deadtime #(
    parameter int LANES = 6,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [DT_W-1:0]  dead_time,
    input  logic [LANES-1:0] req,
    output logic [LANES-1:0] on
);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [DT_W-1:0] wait_q;
        logic            on_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                wait_q <= '0;
                on_q   <= 1'b0;
            end else begin
                if (!req[g]) begin
                    wait_q <= '0;
                end else if (wait_q != dead_time) begin
                    wait_q <= wait_q + 1'b1;
                end
                on_q <= req[g] && (wait_q == dead_time);
            end
        end

        assign on[g] = on_q;
    end

endmodule

// File: rtl/ss_guard.sv
module ss_guard (
    input  logic clk,
    input  logic rst,
    input  logic brk_in,
    input  logic moe_set,
    input  logic aoe_en,
    input  logic upd_evt,
    output logic brk_s,
    output logic moe
);

    logic [1:0] sync_q;
    logic       moe_q;

    assign brk_s = sync_q[1];
    assign moe   = moe_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q <= 2'b00;
            moe_q  <= 1'b0;
        end else begin
            sync_q <= {sync_q[0], brk_in};
            if (brk_s) begin
                moe_q <= 1'b0;
            end else if (moe_set || (aoe_en && upd_evt)) begin
                moe_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/sixstep_seq.sv
module sixstep_seq
    import sixstep_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int DT_W  = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period,
    input  logic [DT_W-1:0]  dead_time,
    input  logic [5:0]       idle_lvl,
    input  logic             moe_set,
    input  logic             aoe_en,
    input  logic             brk_in,
    input  logic             shadow_wr,
    input  logic [2:0]       shadow_step,
    input  logic             com_strobe,
    input  logic             com_trig,
    input  logic             flag_clr,
    output logic [CNT_W-1:0] count,
    output logic             upd_evt,
    output logic [2:0]       step_idx,
    output logic             moe,
    output logic             com_flag,
    output logic [5:0]       drv
);

    logic     com_evt;
    logic     brk_s;
    step_e    active_step;
    drv_vec_t raw_pat;
    drv_vec_t dt_on;

    ss_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk     (clk),
        .rst     (rst),
        .period  (period),
        .count   (count),
        .upd_evt (upd_evt)
    );

    ss_commute u_com (
        .clk         (clk),
        .rst         (rst),
        .shadow_wr   (shadow_wr),
        .shadow_step (shadow_step),
        .com_strobe  (com_strobe),
        .com_trig    (com_trig),
        .flag_clr    (flag_clr),
        .com_evt     (com_evt),
        .active_step (active_step),
        .raw_pat     (raw_pat),
        .com_flag    (com_flag)
    );

    ss_deadtime #(.LANES(NUM_OUT), .DT_W(DT_W)) u_dt (
        .clk       (clk),
        .rst       (rst),
        .dead_time (dead_time),
        .req       (raw_pat),
        .on        (dt_on)
    );

    ss_guard u_grd (
        .clk     (clk),
        .rst     (rst),
        .brk_in  (brk_in),
        .moe_set (moe_set),
        .aoe_en  (aoe_en),
        .upd_evt (upd_evt),
        .brk_s   (brk_s),
        .moe     (moe)
    );

    assign step_idx = active_step;
    assign drv      = (moe && !brk_s) ? dt_on : idle_lvl;

endmodule

// File: rtl/sixstep_seq_chk.sv
module sixstep_seq_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic [CNT_W-1:0] period,
    input logic [5:0]       idle_lvl,
    input logic             com_strobe,
    input logic             com_evt,
    input logic             brk_s,
    input logic [CNT_W-1:0] count,
    input logic [2:0]       step_idx,
    input logic             moe,
    input logic             com_flag,
    input logic [5:0]       drv
);

    // R1: active step is always a legal step number
    a_r1_step_legal: assert property (@(posedge clk) disable iff (rst)
        (step_idx != 3'd0) && (step_idx != 3'd7));

    // R3: no commutation event, no step change
    a_r3_step_hold: assert property (@(posedge clk) disable iff (rst)
        !com_evt |=> $stable(step_idx));

    // R5: a strobe always leaves the flag set
    a_r5_flag_set: assert property (@(posedge clk) disable iff (rst)
        com_strobe |=> com_flag);

    // R6: counter returns to zero after reaching the period
    a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
        (count >= period) && $stable(period) |=> (count == '0));

    // R7: never both legs of a phase driven while enabled
    a_r7_no_overlap: assert property (@(posedge clk) disable iff (rst)
        (moe && !brk_s) |-> ((drv[0] & drv[1]) | (drv[2] & drv[3]) | (drv[4] & drv[5])) == 1'b0);

    // R8: synchronized break forces idle pins and drops the enable
    a_r8_break_idle: assert property (@(posedge clk) disable iff (rst)
        brk_s |-> (drv == idle_lvl));

    a_r8_moe_drop: assert property (@(posedge clk) disable iff (rst)
        brk_s |=> !moe);

    // R9: disabled outputs sit at idle
    a_r9_idle_off: assert property (@(posedge clk) disable iff (rst)
        !moe |-> (drv == idle_lvl));

endmodule

bind sixstep_seq sixstep_seq_chk #(.CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .period     (period),
    .idle_lvl   (idle_lvl),
    .com_strobe (com_strobe),
    .com_evt    (com_evt),
    .brk_s      (brk_s),
    .count      (count),
    .step_idx   (step_idx),
    .moe        (moe),
    .com_flag   (com_flag),
    .drv        (drv)
);

// File: tb/sixstep_seq_test.sv
module sixstep_seq_test;

    localparam int CLK_NS = 10;
    localparam int CW     = 16;
    localparam int DW     = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [CW-1:0] period;
    logic [DW-1:0] dead_time;
    logic [5:0]    idle_lvl;
    logic          moe_set, aoe_en, brk_in;
    logic          shadow_wr;
    logic [2:0]    shadow_step;
    logic          com_strobe, com_trig, flag_clr;
    logic [CW-1:0] count;
    logic          upd_evt;
    logic [2:0]    step_idx;
    logic          moe, com_flag;
    logic [5:0]    drv;

    int checks = 0;
    int fails  = 0;

    sixstep_seq #(.CNT_W(CW), .DT_W(DW)) uut (
        .clk(clk), .rst(rst), .period(period), .dead_time(dead_time),
        .idle_lvl(idle_lvl), .moe_set(moe_set), .aoe_en(aoe_en), .brk_in(brk_in),
        .shadow_wr(shadow_wr), .shadow_step(shadow_step), .com_strobe(com_strobe),
        .com_trig(com_trig), .flag_clr(flag_clr), .count(count), .upd_evt(upd_evt),
        .step_idx(step_idx), .moe(moe), .com_flag(com_flag), .drv(drv)
    );

    always #(CLK_NS/2) clk = ~clk;

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic pulse_strobe();
        com_strobe = 1'b1;
        tick();
        com_strobe = 1'b0;
    endtask

    task automatic write_shadow(logic [2:0] v);
        shadow_wr = 1'b1; shadow_step = v;
        tick();
        shadow_wr = 1'b0;
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick();
        flag_clr = 1'b0;
    endtask

    task automatic t_reset();
        check("R1 step", step_idx, 1);
        check("R1 moe", moe, 0);
        check("R1 flag", com_flag, 0);
        check("R1 count", count, 0);
        check("R1 drv idle", drv, 6'h3F);
    endtask

    task automatic t_timebase();
        logic [CW-1:0] prev;
        int bad = 0;
        prev = count;
        for (int i = 0; i < 40; i++) begin
            tick();
            if (count !== ((prev == period) ? '0 : prev + 1'b1)) bad++;
            if (upd_evt !== (count == period)) bad++;
            prev = count;
        end
        check("R6 count sequence and update", bad, 0);
    endtask

    task automatic t_idle();
        idle_lvl = 6'h15;
        #1;
        check("R9 idle level while disabled", drv, 6'h15);
        idle_lvl = 6'h3F;
    endtask

    task automatic t_enable();
        moe_set = 1'b1;
        tick();
        moe_set = 1'b0;
        check("R9 moe set", moe, 1);
        tick(); tick();
        check("R2 step1 pattern", drv, 6'b001001);
    endtask

    task automatic t_preload();
        write_shadow(3'd4);
        tick(); tick();
        check("R3 step held after write", step_idx, 1);
        check("R3 drv held after write", drv, 6'b001001);
    endtask

    task automatic t_strobe_dead();
        pulse_strobe();
        check("R4 strobe loads step", step_idx, 4);
        check("R5 flag set", com_flag, 1);
        check("R7 old outputs hold at E", drv, 6'b001001);
        tick();
        check("R7 gap after E+1", drv, 6'b000000);
        tick();
        check("R2 step4 pattern at E+2", drv, 6'b000110);
    endtask

    task automatic t_flag();
        clear_flag();
        check("R5 flag cleared", com_flag, 0);
        com_strobe = 1'b1; flag_clr = 1'b1;
        tick();
        com_strobe = 1'b0; flag_clr = 1'b0;
        check("R5 set wins over clear", com_flag, 1);
        clear_flag();
    endtask

    task automatic t_dead3();
        dead_time = 3;
        write_shadow(3'd5);
        pulse_strobe();
        tick();
        check("R7 off leg drops E+1", drv, 6'b000100);
        tick(); tick();
        check("R7 still off at E+3", drv, 6'b000100);
        tick();
        check("R2 step5 pattern at E+4", drv, 6'b100100);
        dead_time = 1;
    endtask

    task automatic t_trig();
        write_shadow(3'd6);
        com_trig = 1'b1;
        tick();
        check("R4 trigger edge loads step", step_idx, 6);
        clear_flag();
        write_shadow(3'd1);
        tick(); tick();
        check("R4 held trigger no new event", step_idx, 6);
        check("R4 held trigger no flag", com_flag, 0);
        com_trig = 1'b0;
        tick();
        com_trig = 1'b1;
        tick();
        check("R4 second edge loads step", step_idx, 1);
        com_trig = 1'b0;
        tick();
        clear_flag();
    endtask

    task automatic t_both();
        write_shadow(3'd2);
        com_strobe = 1'b1; com_trig = 1'b1;
        tick();
        com_strobe = 1'b0; com_trig = 1'b0;
        check("R4 strobe+edge one event", step_idx, 2);
        check("R5 flag after joint event", com_flag, 1);
        clear_flag();
    endtask

    task automatic t_write_same();
        write_shadow(3'd3);
        shadow_wr = 1'b1; shadow_step = 3'd5; com_strobe = 1'b1;
        tick();
        shadow_wr = 1'b0; com_strobe = 1'b0;
        check("R3 event uses old shadow", step_idx, 3);
        pulse_strobe();
        check("R3 new shadow on next event", step_idx, 5);
    endtask

    task automatic t_invalid();
        write_shadow(3'd6);
        write_shadow(3'd7);
        write_shadow(3'd0);
        pulse_strobe();
        check("R3 invalid writes ignored", step_idx, 6);
        clear_flag();
        tick(); tick();
        check("R2 step6 pattern", drv, 6'b100001);
    endtask

    task automatic t_break_com();
        shadow_wr = 1'b1; shadow_step = 3'd1; brk_in = 1'b1;
        tick();
        shadow_wr = 1'b0;
        check("R8 sync delay first edge", drv, 6'b100001);
        com_strobe = 1'b1;
        tick();
        com_strobe = 1'b0;
        check("R8 idle beats commutation", drv, 6'h3F);
        check("R8 step still loads", step_idx, 1);
        tick();
        check("R8 moe cleared", moe, 0);
        brk_in = 1'b0;
        for (int i = 0; i < 40; i++) tick();
        check("R9 no auto reenable", moe, 0);
        check("R9 drv idle after break", drv, 6'h3F);
        moe_set = 1'b1;
        tick();
        moe_set = 1'b0;
        check("R9 moe set after break", moe, 1);
        clear_flag();
    endtask

    task automatic t_aoe();
        int found = 0;
        int cnt_at = -1;
        aoe_en = 1'b1;
        brk_in = 1'b1;
        tick(); tick(); tick();
        check("R8 moe cleared again", moe, 0);
        brk_in = 1'b0;
        for (int i = 0; i < 60; i++) begin
            tick();
            if (found == 0 && moe === 1'b1) begin
                found = 1;
                cnt_at = int'(count);
            end
        end
        check("R10 auto reenable happened", found, 1);
        check("R10 reenable at update", cnt_at, 0);
        aoe_en = 1'b0;
    endtask

    initial begin
        #(CLK_NS * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        rst = 1'b1; period = 15; dead_time = 1; idle_lvl = 6'h3F;
        moe_set = 0; aoe_en = 0; brk_in = 0; shadow_wr = 0; shadow_step = 3'd1;
        com_strobe = 0; com_trig = 0; flag_clr = 0;
        tick(); tick(); tick();
        rst = 1'b0;
        t_reset();
        t_timebase();
        t_idle();
        t_enable();
        t_preload();
        t_strobe_dead();
        t_flag();
        t_dead3();
        t_trig();
        t_both();
        t_write_same();
        t_invalid();
        t_break_com();
        t_aoe();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule